// File: doc/BRIEF.md
# Seven-to-one display link serializer

This block turns a 28-bit pixel word into five serial lanes for a display link. The pixel word carries colour bits together with horizontal sync, vertical sync and data-enable. Four data lanes each carry 7 bits of the word. A fifth lane carries a framing clock. The block runs on a bit clock at seven times the pixel rate. It samples the pixel clock as an ordinary input and captures the word on the pixel clock edge that software selects. Each word is sent during the pixel period after the one in which it was captured.

The word stream has no valid/ready handshake. The source presents one word per pixel clock period, and the block takes every word with no back-pressure. Three control pins set the operating point, and each is a plain level:

- The run pin selects active operation or sleep.
- The edge pin selects whether the word is captured on the rising or the falling pixel clock edge.
- The width pin selects 24-bit colour (all four lanes) or 18-bit colour (top lane off).

In sleep, and when the pixel clock stops for too long, every output is held at logic 0. Serial output starts again only after a fresh word has been captured.

Top module: `pixlink_ser7`

## Requirements
- R1: While reset is asserted, and after reset with `run_en` low, `lane_data` and `lane_clk` are 0.
- R2: Data lane n carries pixel bits [7n+6:7n] most-significant bit first. Slot 0 is the first bit clock cycle after the rising pixel clock edge is sampled. The word captured during pixel period i is sent in slots 0..6 of period i+1.
- R3: `lane_clk` is high in slots 0 to 3 and low in slots 4 to 6 of every live pixel period, so it is never high for more than 4 bit clocks in a row.
- R4: With `edge_rise` = 1, the word present at the rising pixel clock edge is the one captured.
- R5: With `edge_rise` = 0, the word present at the falling pixel clock edge is the one captured.
- R6: With `wide_color` = 0, `lane_data[3]` is 0 and pixel bits [27:21] have no effect on any output.
- R7: Sleep (`run_en` = 0) forces every output to 0 from the bit clock cycle after it is sampled, even in the middle of a word.
- R8: After wake-up, every output stays 0 for the first pixel period. Serial data starts in the second pixel period, carrying the first captured word.
- R9: When no rising pixel clock edge arrives for `IDLE_LIMIT` bit clocks, the outputs go dark. When the pixel clock resumes, the first pixel period after it is dark again, as after wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel rate and phase-aligned to it |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on `bit_clk` |
| run_en | input | 1 | 1 = active, 0 = sleep |
| edge_rise | input | 1 | 1 = capture on the rising pixel edge, 0 = capture on the falling pixel edge |
| wide_color | input | 1 | 1 = 24-bit colour on four lanes, 0 = 18-bit colour with lane 3 off |
| pix_word | input | 28 | Pixel word: colour, syncs and data-enable |
| lane_data | output | 4 | Serial data lanes, bit n = lane n |
| lane_clk | output | 1 | Framing clock lane |

## Verification
The bench changes the pixel word between the rising and falling pixel edges. A design that ignored the edge pin, or used the wrong edge, would therefore send the other word. It fills the top lane's input bits with ones in 18-bit mode, which catches a lane left ungated or bits leaking into the captured word. It puts the design to sleep in the middle of a word, and a design that waited for the word boundary would keep shifting bits out. It also stops the pixel clock and then restarts it. A design without the idle trip would send a stale word in the first period after the restart instead of staying dark.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;

  // Link sequencing state.
  typedef enum logic [1:0] {
    LK_DARK  = 2'd0,  // outputs dark, no fresh word held
    LK_ARMED = 2'd1,  // a word is held, waiting for the next pixel rise
    LK_LIVE  = 2'd2   // streaming
  } link_state_e;

  // Number of bit slots in which the framing lane is high.
  function automatic int high_slots(input int lane_w);
    return (lane_w + 1) / 2;
  endfunction

endpackage

// File: rtl/pixlink_capture.sv
module pixlink_capture #(
  parameter int LANE_W     = 7,
  parameter int N_LANES    = 4,
  parameter int IDLE_LIMIT = 32,
  localparam int WORD_W    = LANE_W * N_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              pix_clk,
  input  logic              edge_rise,
  input  logic              wide_color,
  input  logic [WORD_W-1:0] pix_word,
  output logic              rise_seen,
  output logic              cap_seen,
  output logic              idle_trip,
  output logic [WORD_W-1:0] hold_word
);

  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(IDLE_LIMIT);
  localparam logic [CW-1:0] CNT_TRIP = CW'(IDLE_LIMIT - 1);

  logic              pclk_q;
  logic              fall_seen;
  logic [CW-1:0]     idle_cnt;
  logic [WORD_W-1:0] keep_mask;

  // Pixel clock history, sampled on the bit clock.
  always_ff @(posedge clk) begin
    if (!rst_n) pclk_q <= 1'b0;
    else        pclk_q <= pix_clk;
  end

  assign rise_seen = pix_clk & ~pclk_q;
  assign fall_seen = ~pix_clk & pclk_q;
  assign cap_seen  = run_en & (edge_rise ? rise_seen : fall_seen);

  // The top lane's bits are kept only in wide colour mode.
  for (genvar n = 0; n < N_LANES; n++) begin : g_mask
    if (n == N_LANES - 1) begin : g_opt
      assign keep_mask[n*LANE_W +: LANE_W] = {LANE_W{wide_color}};
    end else begin : g_fix
      assign keep_mask[n*LANE_W +: LANE_W] = {LANE_W{1'b1}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        hold_word <= '0;
    else if (cap_seen) hold_word <= pix_word & keep_mask;
  end

  // Count bit clocks since the last rising pixel edge.
  always_ff @(posedge clk) begin
    if (!rst_n)                idle_cnt <= '0;
    else if (rise_seen)        idle_cnt <= '0;
    else if (idle_cnt != CNT_MAX) idle_cnt <= idle_cnt + 1'b1;
  end

  assign idle_trip = ~rise_seen & (idle_cnt >= CNT_TRIP);

endmodule

// File: rtl/pixlink_ctrl.sv
module pixlink_ctrl
  import pixlink_pkg::*;
#(
  parameter int LANE_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic rise_seen,
  input  logic cap_seen,
  input  logic idle_trip,
  output logic load,
  output logic live,
  output logic frame_clk
);

  localparam int SW = $clog2(LANE_W);
  localparam logic [SW-1:0] SLOT_LAST = SW'(LANE_W - 1);
  localparam logic [SW-1:0] SLOT_HI   = SW'(high_slots(LANE_W));

  link_state_e state_q, state_d;
  logic [SW-1:0] slot_q;

  // A held word is sent from the next rising pixel edge.
  assign load = run_en & rise_seen & (state_q != LK_DARK);

  always_comb begin
    state_d = state_q;
    if (!run_en || idle_trip) begin
      state_d = LK_DARK;
    end else begin
      unique case (state_q)
        LK_DARK:  if (cap_seen) state_d = LK_ARMED;
        LK_ARMED: if (rise_seen) state_d = LK_LIVE;
        LK_LIVE:  state_d = LK_LIVE;
        default:  state_d = LK_DARK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LK_DARK;
    else        state_q <= state_d;
  end

  // Slot counter: restarts on load and holds at the last slot.
  always_ff @(posedge clk) begin
    if (!rst_n)                  slot_q <= SLOT_LAST;
    else if (load)               slot_q <= '0;
    else if (slot_q != SLOT_LAST) slot_q <= slot_q + 1'b1;
  end

  assign live      = (state_q == LK_LIVE);
  assign frame_clk = live & (slot_q < SLOT_HI);

endmodule

// File: rtl/pixlink_lane.sv
module pixlink_lane #(
  parameter int LANE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LANE_W-1:0] par_in,
  input  logic              lane_on,
  input  logic              live,
  output logic              ser_out
);

  logic [LANE_W-1:0] shreg;

  // Load on slot 0, then shift the most-significant bit out first.
  always_ff @(posedge clk) begin
    if (!rst_n)    shreg <= '0;
    else if (load) shreg <= par_in;
    else           shreg <= {shreg[LANE_W-2:0], 1'b0};
  end

  assign ser_out = live & lane_on & shreg[LANE_W-1];

endmodule

// File: rtl/pixlink_ser7.sv
module pixlink_ser7 #(
  parameter int LANE_W     = 7,
  parameter int N_LANES    = 4,
  parameter int IDLE_LIMIT = 32,
  localparam int WORD_W    = LANE_W * N_LANES
) (
  input  logic               bit_clk,
  input  logic               rst_n,
  input  logic               pix_clk,
  input  logic               run_en,
  input  logic               edge_rise,
  input  logic               wide_color,
  input  logic [WORD_W-1:0]  pix_word,
  output logic [N_LANES-1:0] lane_data,
  output logic               lane_clk
);

  logic              rise_seen;
  logic              cap_seen;
  logic              idle_trip;
  logic              load;
  logic              live;
  logic [WORD_W-1:0] hold_word;

  pixlink_capture #(
    .LANE_W     (LANE_W),
    .N_LANES    (N_LANES),
    .IDLE_LIMIT (IDLE_LIMIT)
  ) u_capture (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .pix_clk    (pix_clk),
    .edge_rise  (edge_rise),
    .wide_color (wide_color),
    .pix_word   (pix_word),
    .rise_seen  (rise_seen),
    .cap_seen   (cap_seen),
    .idle_trip  (idle_trip),
    .hold_word  (hold_word)
  );

  pixlink_ctrl #(
    .LANE_W (LANE_W)
  ) u_ctrl (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .rise_seen (rise_seen),
    .cap_seen  (cap_seen),
    .idle_trip (idle_trip),
    .load      (load),
    .live      (live),
    .frame_clk (lane_clk)
  );

  for (genvar n = 0; n < N_LANES; n++) begin : g_lane
    logic lane_on;
    if (n == N_LANES - 1) begin : g_opt
      assign lane_on = wide_color;
    end else begin : g_fix
      assign lane_on = 1'b1;
    end

    pixlink_lane #(
      .LANE_W (LANE_W)
    ) u_lane (
      .clk     (bit_clk),
      .rst_n   (rst_n),
      .load    (load),
      .par_in  (hold_word[n*LANE_W +: LANE_W]),
      .lane_on (lane_on),
      .live    (live),
      .ser_out (lane_data[n])
    );
  end

endmodule

// File: rtl/pixlink_ser7_chk.sv
module pixlink_ser7_chk #(
  parameter int LANE_W     = 7,
  parameter int N_LANES    = 4,
  parameter int IDLE_LIMIT = 32
) (
  input logic               bit_clk,
  input logic               rst_n,
  input logic               pix_clk,
  input logic               run_en,
  input logic               wide_color,
  input logic [N_LANES-1:0] lane_data,
  input logic               lane_clk
);

  localparam int HI = (LANE_W + 1) / 2;
  localparam int CW = $clog2(IDLE_LIMIT + 3) + 1;
  localparam logic [CW-1:0] C_SAT = CW'(IDLE_LIMIT + 2);

  logic [3:0]    hi_run;
  logic [CW-1:0] quiet;
  logic          pq;

  // Consecutive high cycles already seen on the framing lane.
  always_ff @(posedge bit_clk) begin
    if (!rst_n)        hi_run <= '0;
    else if (!lane_clk) hi_run <= '0;
    else if (hi_run != 4'hF) hi_run <= hi_run + 1'b1;
  end

  // Bit clocks since the pixel clock last went high.
  always_ff @(posedge bit_clk) begin
    if (!rst_n) begin
      pq    <= 1'b0;
      quiet <= '0;
    end else begin
      pq <= pix_clk;
      if (pix_clk && !pq)  quiet <= '0;
      else if (quiet != C_SAT) quiet <= quiet + 1'b1;
    end
  end

  assert_clk_high_max_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    lane_clk |-> (32'(hi_run) < HI));

  assert_narrow_top_dark_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !wide_color |-> !lane_data[N_LANES-1]);

  assert_sleep_dark_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !run_en |=> (lane_data == '0 && !lane_clk));

  assert_wake_quiet_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(run_en) |=> (lane_data == '0 && !lane_clk));

  assert_idle_dark_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (quiet == C_SAT) |-> (lane_data == '0 && !lane_clk));

endmodule

bind pixlink_ser7 pixlink_ser7_chk #(
  .LANE_W     (LANE_W),
  .N_LANES    (N_LANES),
  .IDLE_LIMIT (IDLE_LIMIT)
) u_chk (
  .bit_clk    (bit_clk),
  .rst_n      (rst_n),
  .pix_clk    (pix_clk),
  .run_en     (run_en),
  .wide_color (wide_color),
  .lane_data  (lane_data),
  .lane_clk   (lane_clk)
);

// File: tb/test_pixlink_ser7.sv
module test_pixlink_ser7;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 7;
  localparam int NL = 4;
  localparam int WW = LW * NL;

  logic          bit_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_clk = 1'b0;
  logic          run_en = 1'b0;
  logic          edge_rise = 1'b1;
  logic          wide_color = 1'b1;
  logic [WW-1:0] pix_word = '0;
  logic [NL-1:0] lane_data;
  logic          lane_clk;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model state
  bit            m_armed = 1'b0;
  bit            m_live = 1'b0;
  logic [WW-1:0] m_held = '0;
  logic [WW-1:0] m_out = '0;

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  pixlink_ser7 #(.LANE_W(LW), .N_LANES(NL), .IDLE_LIMIT(32)) i_pixlink_ser7 (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .pix_clk    (pix_clk),
    .run_en     (run_en),
    .edge_rise  (edge_rise),
    .wide_color (wide_color),
    .pix_word   (pix_word),
    .lane_data  (lane_data),
    .lane_clk   (lane_clk)
  );

  task automatic chk(input string req, input logic [NL:0] act, input logic [NL:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {clk,lanes} got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WW-1:0] keep(input logic [WW-1:0] w);
    return wide_color ? w : (w & {{LW{1'b0}}, {(WW-LW){1'b1}}});
  endfunction

  function automatic logic [NL:0] slot_exp(input int k);
    logic [NL:0] e;
    e = '0;
    if (m_live) begin
      for (int n = 0; n < NL; n++)
        e[n] = m_out[LW*n + LW-1 - k] & ((n != NL-1) || wide_color);
      e[NL] = (k < 4);
    end
    return e;
  endfunction

  // One pixel period: word wa at the rising edge, wb at the falling edge.
  task automatic pixel(input logic [WW-1:0] wa, input logic [WW-1:0] wb, input string req);
    if (m_armed && run_en) begin
      m_live = 1'b1;
      m_out  = m_held;
    end
    pix_clk  = 1'b1;
    pix_word = wa;
    for (int k = 0; k < LW; k++) begin
      @(posedge bit_clk);
      @(negedge bit_clk);
      chk(req, {lane_clk, lane_data}, slot_exp(k));
      if (k == 3) begin
        pix_clk  = 1'b0;
        pix_word = wb;
      end
    end
    if (run_en) begin
      m_held  = keep(edge_rise ? wa : wb);
      m_armed = 1'b1;
    end
  endtask

  task automatic go_sleep();
    run_en  = 1'b0;
    pix_clk = 1'b0;
    repeat (3) @(negedge bit_clk);
    m_armed = 1'b0;
    m_live  = 1'b0;
  endtask

  task automatic wake();
    run_en = 1'b1;
    @(negedge bit_clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge bit_clk);
    chk("R1", {lane_clk, lane_data}, '0);
    rst_n = 1'b1;
    @(negedge bit_clk);
    chk("R1", {lane_clk, lane_data}, '0);
    pixel(28'h5A5A5A5, 28'h1234567, "R1");
    pixel(28'hFFFFFFF, 28'hFFFFFFF, "R1");
  endtask

  task automatic t_rise_stream();
    go_sleep();
    edge_rise = 1'b1;
    wide_color = 1'b1;
    wake();
    pixel(28'hAB3C1F2, 28'h0000000, "R8");
    pixel(28'h1F0E3D7, 28'h7FFFFFF, "R4");
    pixel(28'hFFFFFFF, 28'h0000001, "R2");
    pixel(28'h8000001, 28'hC30C30C, "R3");
    pixel(28'h0000000, 28'h0000000, "R2");
  endtask

  task automatic t_fall_stream();
    go_sleep();
    edge_rise = 1'b0;
    wake();
    pixel(28'h0000000, 28'h6DB6DB6, "R8");
    pixel(28'hFFFFFFF, 28'h2468ACE, "R5");
    pixel(28'h0F0F0F0, 28'h8000000, "R5");
    pixel(28'h1111111, 28'h0000000, "R5");
  endtask

  task automatic t_narrow();
    go_sleep();
    edge_rise = 1'b1;
    wide_color = 1'b0;
    wake();
    pixel(28'hFE00000, 28'h0, "R6");
    pixel(28'hFE55AA5, 28'h0, "R6");
    pixel(28'hFFFFFFF, 28'h0, "R6");
    pixel(28'h0000000, 28'h0, "R6");
    go_sleep();
    wide_color = 1'b1;
  endtask

  task automatic t_sleep_mid();
    go_sleep();
    edge_rise = 1'b1;
    wake();
    pixel(28'hFFFFFFF, 28'h0, "R8");
    pixel(28'hFFFFFFF, 28'h0, "R2");
    pix_clk  = 1'b1;
    pix_word = 28'h0;
    @(posedge bit_clk);
    @(negedge bit_clk);
    chk("R7", {lane_clk, lane_data}, 5'b11111);
    run_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(posedge bit_clk);
      @(negedge bit_clk);
      chk("R7", {lane_clk, lane_data}, '0);
    end
    go_sleep();
  endtask

  task automatic t_idle();
    go_sleep();
    edge_rise = 1'b0;
    wake();
    pixel(28'h0, 28'h3F3F3F3, "R8");
    pixel(28'h0, 28'hFFFFFFF, "R2");
    pixel(28'h0, 28'h5555555, "R2");
    repeat (40) @(negedge bit_clk);
    chk("R9", {lane_clk, lane_data}, '0);
    m_armed = 1'b0;
    m_live  = 1'b0;
    pixel(28'h0, 28'h0ABCDEF, "R9");
    pixel(28'h0, 28'h0, "R9");
  endtask

  initial begin
    t_reset();
    t_rise_stream();
    t_fall_stream();
    t_narrow();
    t_sleep_mid();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule